// File: doc/BRIEF.md
# E1 Timeslot-Zero Frame Generator

This block produces the outgoing 2048 kbit/s E1 bit stream, one bit per clock enable period. It builds a 125 µs frame of 32 eight-bit timeslots. Each timeslot leaves most-significant bit first, and the first bit on the line is called bit 1. A bit/timeslot/frame position counter drives a shift register. In timeslot 0 the generator writes its own synchronisation byte. Even frames carry the alignment word. Odd frames carry the non-alignment word, which holds the far-end alarm bit and five user-supplied spare bits. Timeslots 1 to 31 are copied from a parallel payload byte that the block requests one timeslot at a time.

Bit 1 of timeslot 0 comes from one of two inputs. With the CRC mode input high it is an externally computed CRC bit. Otherwise it is a fixed international-use value. Strobes mark the first bit of every frame and of every timeslot, so that downstream line coding and upstream payload sources can stay in step.

Top module: `e1_ts0_framer`

## Requirements
- R1: While `rst` is high, `ser_out`, `frame_stb`, `slot_stb`, `slot_num`, `word_is_fas`, `pay_slot` are all 0. The first clock after `rst` falls emits frame 0, timeslot 0, bit 1, with `frame_stb`=1 and `word_is_fas`=1.
- R2: Frames alternate. Frames 0, 2, 4 … have `word_is_fas`=1, and their timeslot 0 bits 2..8 are 0,0,1,1,0,1,1 in line order.
- R3: Frames 1, 3, 5 … have `word_is_fas`=0, and bit 2 of their timeslot 0 is 1.
- R4: In frames with `word_is_fas`=0, bit 3 of timeslot 0 equals `remote_alarm` as sampled in the cycle where `pay_load`=1 and `pay_slot`=0. Changes at other times are ignored.
- R5: In frames with `word_is_fas`=0, bits 4..8 of timeslot 0 are `nat_bits[4]` down to `nat_bits[0]`, sampled in the same cycle as R4.
- R6: Bit 1 of timeslot 0, in both kinds of frame, is `crc_bit` when `crc_mode`=1 and `intl_bit` when `crc_mode`=0. Both are sampled in the same cycle as R4.
- R7: For timeslots 1..31, the eight bits on `ser_out` are `pay_data[7]` down to `pay_data[0]` as sampled in the cycle where `pay_load`=1 for that timeslot. Values of `pay_data` in other cycles, including the load cycle of timeslot 0, have no effect.
- R8: `frame_stb` is 1 for exactly the cycle that carries bit 1 of timeslot 0.
- R9: `slot_stb` is 1 for exactly the cycle that carries bit 1 of each timeslot. `slot_num` gives the timeslot of the bit on `ser_out`.
- R10: `pay_load` is 1 in the cycle before bit 1 of each timeslot is output. `pay_slot` is the index of that timeslot, counting 0..31 and wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| crc_mode | input | 1 | 1: bit 1 of timeslot 0 comes from crc_bit |
| crc_bit | input | 1 | Externally computed CRC bit |
| intl_bit | input | 1 | Fixed international-use bit value |
| remote_alarm | input | 1 | Far-end alarm indication |
| nat_bits | input | 5 | Spare national-use bits, [4] sent first |
| pay_data | input | 8 | Payload byte for the requested timeslot |
| pay_load | output | 1 | Payload byte is sampled this cycle |
| pay_slot | output | 5 | Timeslot whose byte is sampled |
| ser_out | output | 1 | Serial E1 data |
| frame_stb | output | 1 | First bit of frame |
| slot_stb | output | 1 | First bit of timeslot |
| slot_num | output | 5 | Timeslot of the current output bit |
| word_is_fas | output | 1 | Current frame carries the alignment word |

## Verification
The bench runs 40 consecutive frames. It steps the spare bits through twenty values, and toggles the alarm, the CRC mode, the CRC bit and the international bit with different frame-index bits, so that each source of bit 1 is seen with both polarities in both kinds of frame. Every payload byte is a different function of timeslot and frame number. Between load cycles the payload and alarm/spare inputs are scrambled, which separates "sampled once per timeslot" from "sampled every bit". A reset in mid-frame followed by two more frames shows that the counters and the alternation restart at the alignment frame.

// File: rtl/e1fg_pkg.sv
package e1fg_pkg;

   // Line bits 2..8 of the alignment word, bit 2 at the MSB.
   localparam logic [6:0] ALIGN_TAIL = 7'b0011011;

   // Build the timeslot-0 byte; bit 1 on the line is the returned MSB.
   function automatic logic [7:0] ts0_byte(input logic       is_align,
                                           input logic       first_bit,
                                           input logic       alarm,
                                           input logic [4:0] spare);
      if (is_align)
         return {first_bit, ALIGN_TAIL};
      return {first_bit, 1'b1, alarm, spare};
   endfunction

endpackage

// File: rtl/e1fg_position.sv
module e1fg_position #(
   parameter int SLOTS = 32,
   parameter int BITS  = 8,
   localparam int SW   = $clog2(SLOTS),
   localparam int BW   = $clog2(BITS)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [BW-1:0] bit_idx,
   output logic [SW-1:0] slot_idx,
   output logic          odd_frame
);

   localparam logic [BW-1:0] BIT_LAST  = BW'(BITS - 1);
   localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_idx   <= '0;
         slot_idx  <= '0;
         odd_frame <= 1'b0;
      end else if (bit_idx == BIT_LAST) begin
         bit_idx <= '0;
         if (slot_idx == SLOT_LAST) begin
            slot_idx  <= '0;
            odd_frame <= ~odd_frame;
         end else begin
            slot_idx <= slot_idx + 1'b1;
         end
      end else begin
         bit_idx <= bit_idx + 1'b1;
      end
   end

   // R10: the slot index only moves after the last bit of a slot
   p_slot_hold_r10: assert property (@(posedge clk) disable iff (rst)
      ($past(bit_idx) != BIT_LAST) |-> $stable(slot_idx));

endmodule

// File: rtl/e1fg_ts0_word.sv
module e1fg_ts0_word #(
   parameter int  BITS          = 8,
   parameter bit  CRC_SELECTABLE = 1'b1,
   localparam int NW            = BITS - 3
) (
   input  logic          is_align,
   input  logic          crc_mode,
   input  logic          crc_bit,
   input  logic          intl_bit,
   input  logic          alarm,
   input  logic [NW-1:0] spare,
   output logic [BITS-1:0] word
);
   import e1fg_pkg::*;

   logic first_bit;

   generate
      if (CRC_SELECTABLE) begin : g_crc_mux
         assign first_bit = crc_mode ? crc_bit : intl_bit;
      end else begin : g_fixed
         logic unused_crc;
         assign unused_crc = crc_mode ^ crc_bit;
         assign first_bit  = intl_bit;
      end
   endgenerate

   assign word = ts0_byte(is_align, first_bit, alarm, spare);

endmodule

// File: rtl/e1fg_serializer.sv
module e1fg_serializer #(
   parameter int  BITS  = 8,
   parameter int  SLOTS = 32,
   localparam int SW    = $clog2(SLOTS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [BITS-1:0] word,
   input  logic [SW-1:0]   slot_idx,
   input  logic            odd_frame,
   output logic            ser_out,
   output logic            frame_stb,
   output logic            slot_stb,
   output logic [SW-1:0]   slot_num,
   output logic            word_is_fas
);

   logic [BITS-2:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg       <= '0;
         ser_out     <= 1'b0;
         frame_stb   <= 1'b0;
         slot_stb    <= 1'b0;
         slot_num    <= '0;
         word_is_fas <= 1'b0;
      end else begin
         slot_stb  <= load;
         frame_stb <= load && (slot_idx == '0);
         if (load) begin
            ser_out  <= word[BITS-1];
            shreg    <= word[BITS-2:0];
            slot_num <= slot_idx;
            if (slot_idx == '0)
               word_is_fas <= ~odd_frame;
         end else begin
            ser_out <= shreg[BITS-2];
            shreg   <= {shreg[BITS-3:0], 1'b0};
         end
      end
   end

   // R8: a frame strobe is always also a timeslot strobe
   p_frame_on_slot_r8: assert property (@(posedge clk) disable iff (rst)
      frame_stb |-> slot_stb);
   // R9: slot strobe lasts a single cycle
   p_slot_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      slot_stb |=> !slot_stb);
   // R9: slot number only changes at a slot strobe
   p_slot_num_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !slot_stb |-> $stable(slot_num));
   // R2: the kind of timeslot-0 word flips at every frame start
   p_alternate_r2: assert property (@(posedge clk) disable iff (rst)
      frame_stb |-> (word_is_fas != $past(word_is_fas)));

endmodule

// File: rtl/e1_ts0_framer.sv
module e1_ts0_framer #(
   parameter int  SLOTS          = 32,
   parameter int  BITS           = 8,
   parameter bit  CRC_SELECTABLE = 1'b1,
   localparam int SW             = $clog2(SLOTS),
   localparam int BW             = $clog2(BITS),
   localparam int NW             = BITS - 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            crc_mode,
   input  logic            crc_bit,
   input  logic            intl_bit,
   input  logic            remote_alarm,
   input  logic [NW-1:0]   nat_bits,
   input  logic [BITS-1:0] pay_data,
   output logic            pay_load,
   output logic [SW-1:0]   pay_slot,
   output logic            ser_out,
   output logic            frame_stb,
   output logic            slot_stb,
   output logic [SW-1:0]   slot_num,
   output logic            word_is_fas
);

   generate
      if (BITS != 8) begin : g_bad_bits
         $error("e1_ts0_framer: timeslot width must be 8");
      end
      if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
         $error("e1_ts0_framer: slot count must be a power of two");
      end
   endgenerate

   logic [BW-1:0]   bit_idx;
   logic [SW-1:0]   slot_idx;
   logic            odd_frame;
   logic [BITS-1:0] ts0_word;
   logic [BITS-1:0] next_word;

   e1fg_position #(.SLOTS(SLOTS), .BITS(BITS)) u_pos (
      .clk       (clk),
      .rst       (rst),
      .bit_idx   (bit_idx),
      .slot_idx  (slot_idx),
      .odd_frame (odd_frame)
   );

   e1fg_ts0_word #(.BITS(BITS), .CRC_SELECTABLE(CRC_SELECTABLE)) u_ts0 (
      .is_align (~odd_frame),
      .crc_mode (crc_mode),
      .crc_bit  (crc_bit),
      .intl_bit (intl_bit),
      .alarm    (remote_alarm),
      .spare    (nat_bits),
      .word     (ts0_word)
   );

   assign pay_load  = (bit_idx == '0);
   assign pay_slot  = slot_idx;
   assign next_word = (slot_idx == '0) ? ts0_word : pay_data;

   e1fg_serializer #(.BITS(BITS), .SLOTS(SLOTS)) u_ser (
      .clk         (clk),
      .rst         (rst),
      .load        (pay_load),
      .word        (next_word),
      .slot_idx    (slot_idx),
      .odd_frame   (odd_frame),
      .ser_out     (ser_out),
      .frame_stb   (frame_stb),
      .slot_stb    (slot_stb),
      .slot_num    (slot_num),
      .word_is_fas (word_is_fas)
   );

   // R3: line bit 2 of timeslot 0 separates the two words
   p_nfas_bit2_r3: assert property (@(posedge clk) disable iff (rst)
      frame_stb |=> (ser_out == !word_is_fas));
   // R7: first payload bit on the line is the sampled MSB
   p_payload_msb_r7: assert property (@(posedge clk) disable iff (rst)
      (pay_load && pay_slot != '0) |=> (ser_out == $past(pay_data[BITS-1])));
   // R8: frame strobe lines up with timeslot number 0
   p_frame_slot0_r8: assert property (@(posedge clk) disable iff (rst)
      frame_stb |-> (slot_num == '0));

endmodule

// File: tb/tb_e1_ts0_framer.sv
`timescale 1ns/1ps
module tb_e1_ts0_framer;

   logic       clk = 1'b0;
   logic       rst;
   logic       crc_mode, crc_bit, intl_bit, remote_alarm;
   logic [4:0] nat_bits;
   logic [7:0] pay_data;
   logic       pay_load, ser_out, frame_stb, slot_stb, word_is_fas;
   logic [4:0] pay_slot, slot_num;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   e1_ts0_framer dut (
      .clk(clk), .rst(rst), .crc_mode(crc_mode), .crc_bit(crc_bit),
      .intl_bit(intl_bit), .remote_alarm(remote_alarm), .nat_bits(nat_bits),
      .pay_data(pay_data), .pay_load(pay_load), .pay_slot(pay_slot),
      .ser_out(ser_out), .frame_stb(frame_stb), .slot_stb(slot_stb),
      .slot_num(slot_num), .word_is_fas(word_is_fas)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   task automatic check_reset_state();
      chk(ser_out == 0 && frame_stb == 0 && slot_stb == 0, "R1 reset outputs",
          {ser_out, frame_stb, slot_stb}, 0);
      chk(slot_num == 0 && pay_slot == 0 && word_is_fas == 0, "R1 reset state",
          {slot_num, pay_slot, word_is_fas}, 0);
   endtask

   // Runs n bit periods starting at frame 0, timeslot 0, bit 1.
   task automatic run_cycles(input int n);
      logic [7:0] exp_byte = '0;
      for (int k = 0; k < n; k++) begin
         int b = k % 8;
         int s = (k / 8) % 32;
         int f = k / 256;
         string tag;
         chk(pay_load == (b == 0), "R10 pay_load", pay_load, (b == 0));
         chk(pay_slot == s, "R10 pay_slot", pay_slot, s);
         if (b == 0 && s == 0) begin
            crc_mode     = f[2];
            crc_bit      = f[0] ^ f[3];
            intl_bit     = ~f[3];
            remote_alarm = f[1];
            nat_bits     = 5'(((f >> 1) * 13) % 32);
         end
         if (b == 0 && s == 5) begin
            // R4 R5 R6: changes away from the load cycle must be ignored
            remote_alarm = ~remote_alarm;
            nat_bits     = ~nat_bits;
            crc_bit      = ~crc_bit;
            intl_bit     = ~intl_bit;
         end
         if (b == 0) begin
            if (s == 0) begin
               logic b1 = crc_mode ? crc_bit : intl_bit;
               pay_data = 8'hA5 ^ 8'(f);          // R7: ignored in timeslot 0
               exp_byte = (f % 2 == 0) ? {b1, 7'b0011011}
                                       : {b1, 1'b1, remote_alarm, nat_bits};
            end else begin
               pay_data = 8'((s * 37 + f * 11 + 5) % 256);
               exp_byte = pay_data;
            end
         end else begin
            pay_data = ~pay_data;                // R7: not sampled mid-slot
         end
         @(posedge clk);
         @(negedge clk);
         if (s != 0)            tag = "R7 payload bit";
         else if (b == 0)       tag = "R6 bit1 source";
         else if (f % 2 == 0)   tag = "R2 alignment word";
         else if (b == 1)       tag = "R3 non-alignment bit2";
         else if (b == 2)       tag = "R4 alarm bit";
         else                   tag = "R5 national bits";
         chk(ser_out == exp_byte[7 - b], tag, ser_out, exp_byte[7 - b]);
         chk(frame_stb == (b == 0 && s == 0), "R8 frame strobe", frame_stb,
             (b == 0 && s == 0));
         chk(slot_stb == (b == 0), "R9 slot strobe", slot_stb, (b == 0));
         chk(slot_num == s, "R9 slot number", slot_num, s);
         chk(word_is_fas == (f % 2 == 0), "R2 R3 alternation", word_is_fas,
             (f % 2 == 0));
         if (k == 0)
            chk(frame_stb && word_is_fas, "R1 first bit after reset",
                {frame_stb, word_is_fas}, 3);
      end
   endtask

   initial begin
      rst = 1'b1; crc_mode = 0; crc_bit = 0; intl_bit = 1;
      remote_alarm = 0; nat_bits = '0; pay_data = '0;
      repeat (3) @(negedge clk);
      check_reset_state();
      rst = 1'b0;
      run_cycles(40 * 256);
      run_cycles(1000);                          // part of a further pass
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      check_reset_state();                      // R1 mid-frame reset
      @(posedge clk); @(negedge clk);
      check_reset_state();
      rst = 1'b0;
      run_cycles(2 * 256);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

endmodule